// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Cache

This block is a small fully associative cache of virtual-to-physical page translations. A lookup presents a virtual address, the identifier of the current address space and the kind of access (read, write or execute). Within the same cycle the block reports exactly one of three outcomes: a hit with the physical address, a miss, or a protection fault. Every slot is compared at once, so a translation may live in any slot. Each slot holds a page number, a frame number, an 8-bit space tag, a global flag, three permission bits, a valid flag and a dirty flag.

Separate miss-handling logic loads translations through the fill port. A fill whose page number, space tag and global flag match an existing valid slot rewrites that slot. Otherwise the block first uses the lowest-numbered empty slot. When no slot is empty, it evicts the least recently used slot or a pseudo-randomly chosen one. A build parameter selects the eviction policy.

A flush command empties the whole cache, and so does a write to the page-table base. The lookup path is a combinational request/response pair with no back-pressure: `req_valid` qualifies the request and there is no ready signal. The response is valid in the same cycle and is consumed at once. Fill and flush are single-cycle strobes and are always accepted.

Top module: `asid_tlb`

## Requirements
- R1: On a hit, `rsp_paddr` equals the slot's frame number placed above the low OFFS_W bits of `req_vaddr`, which pass through unchanged. The page number is `req_vaddr[VA_W-1:OFFS_W]`. `rsp_paddr` is zero on a miss or a fault.
- R2: While `req_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high, in the same cycle as the request. While `req_valid` is low, all three are low.
- R3: A valid slot matches when its page number equals the request's page number and either its global flag is set or its space tag equals `req_asid`.
- R4: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. `req_acc` is encoded 0 read, 1 write, 2 execute, and 3 is reserved. A match whose permission bit for the access is clear, and every match with code 3, gives `rsp_fault` instead of a hit.
- R5: Reset leaves every slot invalid. A `flush` or `ptbr_wr` pulse invalidates every slot at the next edge, and it wins over a fill in the same cycle.
- R6: When several slots match, the lowest-numbered one supplies the result.
- R7: A fill whose page number, space tag and global flag equal those of a valid slot overwrites that slot and evicts nothing.
- R8: A fill that matches no slot goes to the lowest-numbered invalid slot while any slot is invalid.
- R9: With REPL_LRU=1 and all slots valid, a new fill replaces the slot whose last use is oldest. A use is a fill, or a lookup that matches (hit or fault).
- R10: On a hit, `rsp_dirty` shows the slot's dirty flag. A write hit sets that flag for later lookups, and the fill value loads it.
- R11: Slots with different space tags may hold the same page number with different frames, and different page numbers may map to the same frame. Each lookup returns the frame of its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request qualifier |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space identifier |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Matching slot forbids the access |
| rsp_paddr | output | PA_W | Physical address on hit, else zero |
| rsp_dirty | output | 1 | Dirty flag of the hit slot |
| fill_valid | input | 1 | Load one translation this cycle |
| fill_vpn | input | VA_W-OFFS_W | Page number to load |
| fill_pfn | input | PA_W-OFFS_W | Frame number to load |
| fill_asid | input | ASID_W | Space tag to load |
| fill_global | input | 1 | Global flag to load |
| fill_prot | input | 3 | Permission bits to load (execute, write, read) |
| fill_dirty | input | 1 | Initial dirty flag |
| flush | input | 1 | Invalidate every slot |
| ptbr_wr | input | 1 | Page-table base written; invalidates every slot |

## Verification
The lookup outcome, physical address and dirty flag are combinational. The bench drives each request on a falling edge and samples one nanosecond later, before the next rising edge. Fills, flushes, recency updates and dirty-flag setting take effect at the next rising edge. The first lookup that can observe them is the one issued on the following falling edge, and the bench's model is updated at that same rising edge. Repeated sweeps over every page number, two space identifiers and all four access codes compare each response with the model. These sweeps run after fills, overwrites, evictions and both kinds of flush.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int PROT_W = 3;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  // permission bit for a given access; reserved code is never allowed
  function automatic logic acc_permitted(input logic [PROT_W-1:0] prot, input logic [1:0] acc);
    case (acc)
      ACC_RD:  return prot[0];
      ACC_WR:  return prot[1];
      ACC_EX:  return prot[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/asid_tlb_match.sv
module asid_tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0]             glob_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  output logic                           any_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [ENTRIES-1:0] hit_vec;

  // one comparator per slot, all in parallel
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                        (glob_i[g] || (asid_i[g] == key_asid_i));
  end

  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int ENTRIES  = 32,
  parameter bit REPL_LRU = 1'b1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               touch_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic               have_free;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   policy_idx;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end

  assign victim_o = have_free ? free_idx : policy_idx;

  a_r8_free_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&valid_i)) |-> !valid_i[victim_o]);

  if (REPL_LRU) begin : g_lru
    // age rank per slot: 0 = newest, ENTRIES-1 = oldest; ranks form a permutation
    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [IDX_W-1:0]              touched_age;
    logic [ENTRIES-1:0]            is_oldest;

    assign touched_age = age_q[touch_idx_i];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      assign is_oldest[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          age_q[g] <= IDX_W'(g);
        end else if (touch_i) begin
          if (touch_idx_i == IDX_W'(g))  age_q[g] <= '0;
          else if (age_q[g] < touched_age) age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end

    always_comb begin
      policy_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (is_oldest[i]) policy_idx = IDX_W'(i);
      end
    end

    a_r9_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(is_oldest) == 1);
    a_r9_touch_is_newest: assert property (@(posedge clk) disable iff (!rst_n)
      touch_i |=> age_q[$past(touch_idx_i)] == '0);
  end else begin : g_rand
    localparam int LFSR_W = (IDX_W > 16) ? IDX_W : 16;
    logic [LFSR_W-1:0] lfsr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) lfsr_q <= LFSR_W'(16'hACE1);
      else        lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
    assign policy_idx = lfsr_q[IDX_W-1:0];

    a_r9_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int OFFS_W   = 12,
  parameter int PA_W     = 36,
  parameter int ASID_W   = 8,
  parameter int ENTRIES  = 32,
  parameter bit REPL_LRU = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic [ASID_W-1:0]        req_asid,
  input  logic [1:0]               req_acc,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic [PA_W-1:0]          rsp_paddr,
  output logic                     rsp_dirty,
  input  logic                     fill_valid,
  input  logic [VA_W-OFFS_W-1:0]   fill_vpn,
  input  logic [PA_W-OFFS_W-1:0]   fill_pfn,
  input  logic [ASID_W-1:0]        fill_asid,
  input  logic                     fill_global,
  input  logic [PROT_W-1:0]        fill_prot,
  input  logic                     fill_dirty,
  input  logic                     flush,
  input  logic                     ptbr_wr
);
  localparam int VPN_W = VA_W - OFFS_W;
  localparam int PFN_W = PA_W - OFFS_W;
  localparam int IDX_W = $clog2(ENTRIES);

  // slot storage
  logic [ENTRIES-1:0]              valid_q, glob_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PROT_W-1:0]  prot_q;

  // lookup
  logic [VPN_W-1:0]  req_vpn;
  logic [OFFS_W-1:0] req_off;
  logic              lk_any;
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_ok;

  assign req_vpn = req_vaddr[VA_W-1:OFFS_W];
  assign req_off = req_vaddr[OFFS_W-1:0];

  asid_tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
  ) lookup_cmp_i (
    .valid_i   (valid_q),
    .glob_i    (glob_q),
    .vpn_i     (vpn_q),
    .asid_i    (asid_q),
    .key_vpn_i (req_vpn),
    .key_asid_i(req_asid),
    .any_o     (lk_any),
    .idx_o     (lk_idx)
  );

  assign lk_ok     = acc_permitted(prot_q[lk_idx], req_acc);
  assign rsp_hit   = req_valid &&  lk_any &&  lk_ok;
  assign rsp_fault = req_valid &&  lk_any && !lk_ok;
  assign rsp_miss  = req_valid && !lk_any;
  assign rsp_paddr = rsp_hit ? {pfn_q[lk_idx], req_off} : '0;
  assign rsp_dirty = rsp_hit && dirty_q[lk_idx];

  // fill: rewrite an identical key, else take the victim slot
  logic             dup_any;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] vic_idx;
  logic [IDX_W-1:0] fill_idx;
  logic             wipe;
  logic             do_fill;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;

  always_comb begin
    dup_any = 1'b0;
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && vpn_q[i] == fill_vpn && asid_q[i] == fill_asid && glob_q[i] == fill_global) begin
        dup_any = 1'b1;
        dup_idx = IDX_W'(i);
      end
    end
  end

  assign wipe      = flush || ptbr_wr;
  assign do_fill   = fill_valid && !wipe;
  assign fill_idx  = dup_any ? dup_idx : vic_idx;
  assign touch     = do_fill || (!wipe && req_valid && lk_any);
  assign touch_idx = do_fill ? fill_idx : lk_idx;

  asid_tlb_victim #(
    .ENTRIES(ENTRIES), .REPL_LRU(REPL_LRU)
  ) victim_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_q),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .victim_o   (vic_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel_fill, sel_wr_hit;
    assign sel_fill   = do_fill && (fill_idx == IDX_W'(g));
    assign sel_wr_hit = !wipe && rsp_hit && (req_acc == ACC_WR) && (lk_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        glob_q[g]  <= 1'b0;
        vpn_q[g]   <= '0;
        pfn_q[g]   <= '0;
        asid_q[g]  <= '0;
        prot_q[g]  <= '0;
      end else if (wipe) begin
        valid_q[g] <= 1'b0;
      end else if (sel_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= fill_dirty;
        glob_q[g]  <= fill_global;
        vpn_q[g]   <= fill_vpn;
        pfn_q[g]   <= fill_pfn;
        asid_q[g]  <= fill_asid;
        prot_q[g]  <= fill_prot;
      end else if (sel_wr_hit) begin
        dirty_q[g] <= 1'b1;
      end
    end
  end

  // checks
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(rsp_hit || rsp_miss || rsp_fault));
  a_r5_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (valid_q == '0));
  a_r5_wipe_then_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !(rsp_hit || rsp_fault));
  a_r10_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && req_acc == ACC_WR && !wipe && !fill_valid) |=> dirty_q[$past(lk_idx)]);
  a_r7_rewrite_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && dup_any) |=> $countones(valid_q) == $countones($past(valid_q)));
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFFS_W-1:0] == req_vaddr[OFFS_W-1:0]);
endmodule

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
  localparam int VA_W = 8, OFFS_W = 4, PA_W = 8, ASID_W = 8, N = 4;
  localparam int VPN_W = VA_W - OFFS_W, PFN_W = PA_W - OFFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [ASID_W-1:0] req_asid = '0;
  logic [1:0] req_acc = '0;
  logic rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_paddr;
  logic fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic fill_global = 1'b0;
  logic [2:0] fill_prot = '0;
  logic fill_dirty = 1'b0;
  logic flush = 1'b0;
  logic ptbr_wr = 1'b0;

  always #2 clk = ~clk;

  asid_tlb #(.VA_W(VA_W), .OFFS_W(OFFS_W), .PA_W(PA_W), .ASID_W(ASID_W),
             .ENTRIES(N), .REPL_LRU(1'b1)) dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  bit m_v[N], m_g[N], m_d[N];
  int m_vpn[N], m_pfn[N], m_asid[N], m_prot[N], m_stamp[N];
  int m_clock = 0;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_stamp[i] = N - 1 - i;
    end
    m_clock = N;
  endtask

  task automatic model_find(input int vpn, input int asid, output int idx);
    idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asid[i] == asid)) idx = i;
  endtask

  function automatic int model_slot(input int vpn, input int asid, input bit g);
    int best;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid && m_g[i] == g) return i;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[best]) best = i;
    return best;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic lookup(input int va, input int asid, input int acc, input string tag);
    int idx, pm, pa, eh, ef, em, ed;
    req_valid = 1; req_vaddr = VA_W'(va); req_asid = ASID_W'(asid); req_acc = 2'(acc);
    model_find(va >> OFFS_W, asid, idx);
    pm = (idx >= 0) ? m_prot[idx] : 0;
    eh = (idx >= 0) && acc != 3 && pm[acc];
    ef = (idx >= 0) && !eh;
    em = (idx < 0);
    pa = eh ? ((m_pfn[idx] << OFFS_W) | (va & ((1 << OFFS_W) - 1))) : 0;
    ed = eh ? int'(m_d[idx]) : 0;
    #1;
    check(tag, "outcome{hit,miss,fault}", {rsp_hit, rsp_miss, rsp_fault}, {eh[0], em[0], ef[0]});
    check(tag, "paddr", rsp_paddr, pa);
    check(tag, "dirty", rsp_dirty, ed);
    @(posedge clk);
    if (idx >= 0) begin m_stamp[idx] = m_clock++; if (eh && acc == 1) m_d[idx] = 1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic fill(input int vpn, input int pfn, input int asid, input bit g, input int prot, input bit d);
    int s;
    fill_valid = 1; fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn); fill_asid = ASID_W'(asid);
    fill_global = g; fill_prot = 3'(prot); fill_dirty = d;
    s = model_slot(vpn, asid, g);
    @(posedge clk);
    m_v[s] = 1; m_vpn[s] = vpn; m_pfn[s] = pfn; m_asid[s] = asid; m_g[s] = g;
    m_prot[s] = prot; m_d[s] = d; m_stamp[s] = m_clock++;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic wipe(input bit use_ptbr, input bit with_fill);
    if (use_ptbr) ptbr_wr = 1; else flush = 1;
    fill_valid = with_fill; fill_vpn = 4'h5; fill_pfn = 4'h7; fill_asid = 1; fill_prot = 3'b111;
    @(posedge clk);
    for (int i = 0; i < N; i++) m_v[i] = 0;
    @(negedge clk);
    flush = 0; ptbr_wr = 0; fill_valid = 0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 16; v++)
      for (int a = 1; a <= 2; a++)
        for (int acc = 0; acc < 4; acc++)
          lookup((v << OFFS_W) | ((v * 3 + acc) & 15), a, acc, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R2: idle request drives no outcome
    check("R2", "idle outcome", {rsp_hit, rsp_miss, rsp_fault}, 0);
    @(negedge clk);
    sweep("R5");                         // empty after reset: all miss

    fill(6, 4'hA, 1, 0, 3'b011, 0);      // slot 0
    fill(6, 4'hB, 2, 0, 3'b001, 0);      // slot 1, same page other space
    fill(9, 4'hA, 0, 1, 3'b100, 0);      // slot 2, global, aliased frame
    lookup(8'h64, 1, 0, "R1");
    lookup(8'h6C, 2, 0, "R11");
    lookup(8'h97, 5, 2, "R3");           // global ignores tag
    lookup(8'h65, 5, 0, "R3");           // tag mismatch -> miss
    lookup(8'h63, 2, 1, "R4");           // write to read-only
    lookup(8'h90, 1, 3, "R4");           // reserved code
    lookup(8'h61, 1, 1, "R10");          // write hit sets dirty
    lookup(8'h62, 1, 0, "R10");
    sweep("R2");

    fill(3, 4'h5, 1, 0, 3'b111, 1);      // last free slot
    lookup(8'h3F, 1, 2, "R8");
    lookup(8'h60, 2, 0, "R9");
    lookup(8'h90, 2, 2, "R9");
    fill(12, 4'hC, 1, 0, 3'b111, 0);     // evicts oldest
    sweep("R9");

    fill(12, 4'hE, 1, 0, 3'b001, 0);     // same key: rewrite in place
    lookup(8'hC4, 1, 0, "R7");
    sweep("R7");

    fill(3, 4'h1, 0, 1, 3'b111, 0);
    fill(3, 4'h2, 1, 0, 3'b111, 0);
    lookup(8'h30, 1, 0, "R6");
    sweep("R6");

    wipe(0, 1);                          // flush beats concurrent fill
    sweep("R5");
    fill(6, 4'h3, 1, 0, 3'b111, 0);
    fill(7, 4'h4, 2, 0, 3'b111, 0);
    wipe(1, 0);                          // base-register write
    sweep("R5");

    fill(1, 4'h1, 1, 0, 3'b001, 0);
    fill(2, 4'h2, 1, 0, 3'b011, 0);
    fill(4, 4'h4, 2, 0, 3'b101, 0);
    fill(8, 4'h8, 0, 1, 3'b111, 0);
    sweep("R8");
    lookup(8'h10, 1, 0, "R9");
    fill(15, 4'hF, 2, 0, 3'b111, 0);
    sweep("R9");
    fill(14, 4'h9, 1, 0, 3'b010, 1);
    sweep("R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule